// File: doc/BRIEF.md
# Dual-Mode Low-Power Cache Lookup

This block is the lookup path and control for a small read-only set-associative cache. It is built to save array energy. It never reads all tag and data ways in parallel. The block keeps an eight-entry side table that records, for recently touched sets, which way last supplied a hit. When an incoming request's set index is in that table, the block enables only that one way's tag and data arrays. This prediction probe finishes in a single lookup cycle if the guess is right. If the guess is wrong, the other ways are all enabled together in the next cycle. When the set is not in the table, the block works tags-first: every tag of the set is compared with no data array enabled, and then only the matching way's data array is read.

A request that misses every way raises a refill request toward the next memory level. The returned word is installed into the way named by a per-set round-robin victim pointer, and the request is then replayed. With each response the block reports how many tag-array enables and data-array enables the request consumed in total, so that energy per access can be checked in simulation. Only one request is outstanding at a time.

Top module: `dual_mode_cache`

## Requirements
- R1: The cache has 4 ways of 16 sets with one 32-bit word per line. The set index is req_addr[3:0] and the stored tag is req_addr[31:4]. Two addresses with equal index and different tags occupy different lines.
- R2: After reset req_ready is 1 and rsp_valid and fill_req are 0. req_ready is 1 only while no request is in progress. rsp_valid is a one-cycle pulse per accepted request.
- R3: At acceptance, the request runs in prediction mode if its set index is held in the recency table, and in phased mode otherwise.
- R4: In a correct prediction, rsp_valid is high in the second cycle after the accepting clock edge, with rsp_hit=1, the stored word, rsp_tag_cnt=1 and rsp_data_cnt=1.
- R5: In a wrong prediction that hits, the other three ways' tag and data arrays are enabled together in the next cycle. The response arrives in the third cycle with rsp_tag_cnt=4 and rsp_data_cnt=4.
- R6: A phased hit enables all four tags with no data array, and then exactly one data array. The response arrives in the third cycle with rsp_tag_cnt=4 and rsp_data_cnt=1.
- R7: Every hit records the hitting way as the set's predicted way, so an immediate repeat of the same address is a correct prediction.
- R8: A miss in all ways raises fill_req with fill_addr equal to the request address, both held until fill_valid. The word is installed and the request replayed. The response carries rsp_hit=0 and the refilled word. Totals are 5 tag / 1 data enables for a phased miss and 5 / 5 for a prediction-mode miss.
- R9: Refills of one set go to ways 0, 1, 2, 3, 0 in turn, so the fifth distinct tag in a set evicts the first.
- R10: The recency table holds 8 sets. Inserting a ninth set evicts the set whose entry was least recently inserted or hit; that set's next access runs in phased mode.
- R11: A prediction probe enables exactly one tag array and the same single data array. The first phase of a phased access enables no data array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Word address of the request |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 if served without a refill |
| rsp_data | output | 32 | Returned word |
| rsp_tag_cnt | output | 3 | Tag-array enables spent on this request |
| rsp_data_cnt | output | 3 | Data-array enables spent on this request |
| fill_req | output | 1 | Refill wanted for fill_addr |
| fill_addr | output | 32 | Address to refill |
| fill_valid | input | 1 | Refill word present on fill_data |
| fill_data | input | 32 | Refill word |

## Verification
A corrupted recency table or predicted way shows up on the first later access to that set. The response latency moves between two and three cycles, and the enable counts change, for example from 1/1 to 4/4 or 4/1. A stale victim pointer or lost valid bit shows up as a wrong rsp_hit or wrong data on the next re-read of a line that should have survived or been evicted. A controller that enables the wrong arrays alters the per-response counts in the same response, so each scenario compares latency, hit, data and both counts against values derived from the requirements.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int DEF_WAYS    = 4;
    localparam int DEF_SETS    = 16;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_TBL_ENT = 8;

    typedef enum logic [2:0] {
        S_IDLE,   // ready for a request
        S_PRED,   // single predicted way probed
        S_REST,   // remaining ways probed after a wrong guess
        S_PTAG,   // phased access, all tags compared
        S_PDATA,  // phased access, one data way read
        S_FILL    // waiting for refill word
    } lk_state_e;

    function automatic int cnt_width(input int ways);
        return $clog2(ways + 2);
    endfunction
endpackage

// File: rtl/cache_way.sv
module cache_way #(
    parameter int SETS   = 16,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic              tag_en,
    input  logic              data_en,
    output logic              match,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];
    logic [SETS-1:0]   line_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_vld <= '0;
        end else if (wr_en) begin
            line_vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    // Arrays only produce output when enabled (energy model).
    assign match   = tag_en && line_vld[rd_idx] && (tag_mem[rd_idx] == cmp_tag);
    assign rd_data = data_en ? data_mem[rd_idx] : '0;
endmodule

// File: rtl/mru_table.sv
module mru_table #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 4,
    parameter int WAY_W   = 2,
    localparam int ENT_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [WAY_W-1:0] upd_way
);
    logic             e_vld [ENTRIES];
    logic [IDX_W-1:0] e_set [ENTRIES];
    logic [WAY_W-1:0] e_way [ENTRIES];
    logic [ENT_W-1:0] e_age [ENTRIES];   // ages form a permutation, 0 = newest

    logic             u_found;
    logic [ENT_W-1:0] u_sel, u_old, u_tgt;

    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (e_vld[e] && e_set[e] == lk_idx) begin
                lk_hit = 1'b1;
                lk_way = e_way[e];
            end
        end
    end

    always_comb begin
        u_found = 1'b0;
        u_sel   = '0;
        u_old   = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (e_vld[e] && e_set[e] == upd_idx) begin
                u_found = 1'b1;
                u_sel   = ENT_W'(e);
            end
            if (e_age[e] == ENT_W'(ENTRIES - 1)) begin
                u_old = ENT_W'(e);
            end
        end
        u_tgt = u_found ? u_sel : u_old;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                e_vld[e] <= 1'b0;
                e_set[e] <= '0;
                e_way[e] <= '0;
                e_age[e] <= ENT_W'(e);
            end
        end else if (upd_en) begin
            e_vld[u_tgt] <= 1'b1;
            e_set[u_tgt] <= upd_idx;
            e_way[u_tgt] <= upd_way;
            for (int e = 0; e < ENTRIES; e++) begin
                if (ENT_W'(e) == u_tgt) begin
                    e_age[e] <= '0;
                end else if (e_age[e] < e_age[u_tgt]) begin
                    e_age[e] <= e_age[e] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dual_mode_cache.sv
module dual_mode_cache
    import cache_pkg::*;
#(
    parameter int WAYS        = DEF_WAYS,
    parameter int SETS        = DEF_SETS,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int TBL_ENTRIES = DEF_TBL_ENT,
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - IDX_W,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int CNT_W      = cnt_width(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  rsp_tag_cnt,
    output logic [CNT_W-1:0]  rsp_data_cnt,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    lk_state_e         state;
    logic [ADDR_W-1:0] cur_addr;
    logic [WAY_W-1:0]  pred_way, hit_way;
    logic              refilled;
    logic [WAY_W-1:0]  vptr [SETS];

    logic [IDX_W-1:0]  cur_idx, lk_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              tbl_hit;
    logic [WAY_W-1:0]  tbl_way;
    logic [WAYS-1:0]   tag_en, data_en, match;
    logic [DATA_W-1:0] way_data [WAYS];
    logic              hit_any;
    logic [WAY_W-1:0]  hit_idx, sel_way, victim;
    logic              fill_done, fin, upd_en;
    logic [WAY_W-1:0]  upd_way;

    assign cur_idx   = cur_addr[IDX_W-1:0];
    assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
    assign lk_idx    = (state == S_IDLE) ? req_addr[IDX_W-1:0] : cur_idx;
    assign victim    = vptr[cur_idx];
    assign fill_done = (state == S_FILL) && fill_valid;
    assign req_ready = (state == S_IDLE);
    assign fill_req  = (state == S_FILL);
    assign fill_addr = cur_addr;

    mru_table #(.ENTRIES(TBL_ENTRIES), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_mru (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_hit(tbl_hit), .lk_way(tbl_way),
        .upd_en(upd_en), .upd_idx(cur_idx), .upd_way(upd_way)
    );

    // Array enables per state
    always_comb begin
        tag_en  = '0;
        data_en = '0;
        case (state)
            S_PRED:  begin
                tag_en[pred_way]  = 1'b1;
                data_en[pred_way] = 1'b1;
            end
            S_REST:  begin
                tag_en            = '1;
                tag_en[pred_way]  = 1'b0;
                data_en           = tag_en;
            end
            S_PTAG:  tag_en = '1;
            S_PDATA: data_en[hit_way] = 1'b1;
            default: ;
        endcase
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk(clk), .rst(rst),
            .rd_idx(cur_idx), .cmp_tag(cur_tag),
            .tag_en(tag_en[w]), .data_en(data_en[w]),
            .match(match[w]), .rd_data(way_data[w]),
            .wr_en(fill_done && victim == WAY_W'(w)),
            .wr_idx(cur_idx), .wr_tag(cur_tag), .wr_data(fill_data)
        );
    end

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_any = 1'b1;
                hit_idx = WAY_W'(w);
            end
        end
    end

    // Completion and recency update
    always_comb begin
        fin     = 1'b0;
        upd_en  = 1'b0;
        upd_way = hit_idx;
        sel_way = (state == S_PDATA) ? hit_way : hit_idx;
        case (state)
            S_PRED:  begin fin = match[pred_way]; upd_en = match[pred_way]; end
            S_REST:  begin fin = hit_any;         upd_en = hit_any;         end
            S_PDATA: begin fin = 1'b1; upd_en = 1'b1; upd_way = hit_way;   end
            S_FILL:  begin upd_en = fill_valid; upd_way = victim;           end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            cur_addr     <= '0;
            pred_way     <= '0;
            hit_way      <= '0;
            refilled     <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_data     <= '0;
            rsp_tag_cnt  <= '0;
            rsp_data_cnt <= '0;
            for (int s = 0; s < SETS; s++) vptr[s] <= '0;
        end else begin
            rsp_valid <= fin;
            if (fin) begin
                rsp_hit  <= !refilled;
                rsp_data <= way_data[sel_way];
            end
            if (state == S_IDLE) begin
                if (req_valid) begin
                    cur_addr     <= req_addr;
                    refilled     <= 1'b0;
                    rsp_tag_cnt  <= '0;
                    rsp_data_cnt <= '0;
                    pred_way     <= tbl_way;
                    state        <= tbl_hit ? S_PRED : S_PTAG;
                end
            end else begin
                rsp_tag_cnt  <= rsp_tag_cnt  + CNT_W'($countones(tag_en));
                rsp_data_cnt <= rsp_data_cnt + CNT_W'($countones(data_en));
                case (state)
                    S_PRED:  state <= match[pred_way] ? S_IDLE : S_REST;
                    S_REST:  state <= hit_any ? S_IDLE : S_FILL;
                    S_PTAG:  begin
                        hit_way <= hit_idx;
                        state   <= hit_any ? S_PDATA : S_FILL;
                    end
                    S_PDATA: state <= S_IDLE;
                    S_FILL:  if (fill_valid) begin
                        vptr[cur_idx] <= victim + 1'b1;
                        pred_way      <= victim;
                        refilled      <= 1'b1;
                        state         <= S_PRED;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker
    import cache_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              fill_req,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input lk_state_e         state,
    input logic [WAYS-1:0]   tag_en,
    input logic [WAYS-1:0]   data_en
);
    assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_pred_probe_R11: assert property (@(posedge clk) disable iff (rst)
        (state == S_PRED) |-> ($countones(tag_en) == 1 && data_en == tag_en));

    assert_phase_one_R11: assert property (@(posedge clk) disable iff (rst)
        (state == S_PTAG) |-> ((&tag_en) && data_en == '0));

    assert_phase_two_R6: assert property (@(posedge clk) disable iff (rst)
        (state == S_PDATA) |-> (tag_en == '0 && $countones(data_en) == 1));

    assert_rest_probe_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_REST) |-> ($countones(tag_en) == WAYS - 1 && data_en == tag_en));

    assert_fill_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));
endmodule

bind dual_mode_cache dmc_checker #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .fill_req(fill_req), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .state(state), .tag_en(tag_en), .data_en(data_en)
);

// File: tb/test_dual_mode_cache.sv
`timescale 1ns/1ps
module test_dual_mode_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_hit, fill_req;
    logic [31:0] rsp_data, fill_addr;
    logic [2:0]  rsp_tag_cnt, rsp_data_cnt;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    dual_mode_cache i_dual_mode_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .rsp_tag_cnt(rsp_tag_cnt), .rsp_data_cnt(rsp_data_cnt),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // One request; services the refill; checks hit, data, latency and counts.
    task automatic access(input logic [31:0] a, input logic exp_hit, input int exp_lat,
                          input int exp_t, input int exp_d, input string rq);
        int  lat;
        bit  got;
        @(negedge clk);
        chk(req_ready, {rq, " ready before request (R2)"}, 32'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        got = 1'b0;
        while (!got && lat < 40) begin
            if (rsp_valid) begin
                got = 1'b1;
            end else begin
                if (fill_req && !fill_valid) begin
                    chk(fill_addr == a, {rq, " R8 fill address"}, fill_addr, a);
                    fill_valid = 1'b1;
                    fill_data  = mem_word(fill_addr);
                end else begin
                    fill_valid = 1'b0;
                end
                @(negedge clk);
                lat++;
            end
        end
        fill_valid = 1'b0;
        chk(got, {rq, " response seen"}, 32'(got), 1);
        chk(rsp_hit == exp_hit, {rq, " hit flag"}, 32'(rsp_hit), 32'(exp_hit));
        chk(rsp_data == mem_word(a), {rq, " data"}, rsp_data, mem_word(a));
        if (exp_lat > 0)
            chk(lat == exp_lat, {rq, " latency"}, 32'(lat), 32'(exp_lat));
        if (exp_t >= 0) begin
            chk(rsp_tag_cnt == 3'(exp_t), {rq, " tag enables"}, 32'(rsp_tag_cnt), 32'(exp_t));
            chk(rsp_data_cnt == 3'(exp_d), {rq, " data enables"}, 32'(rsp_data_cnt), 32'(exp_d));
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 reset ready", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R2 reset rsp_valid", 32'(rsp_valid), 0);
        chk(fill_req == 1'b0, "R2 reset fill_req", 32'(fill_req), 0);
    endtask

    task automatic t_cold_then_predict;
        access(32'h0000_0010, 1'b0, -1, 5, 1, "R8 phased miss");
        access(32'h0000_0010, 1'b1, 2, 1, 1, "R4 R3 predicted hit");
    endtask

    task automatic t_mispredict;
        access(32'h0000_0021, 1'b0, -1, 5, 1, "R8 set1 first miss");
        access(32'h0000_0031, 1'b0, -1, 5, 5, "R8 prediction-mode miss");
        access(32'h0000_0021, 1'b1, 3, 4, 4, "R5 mispredict hit");
        access(32'h0000_0021, 1'b1, 2, 1, 1, "R7 recency updated");
    endtask

    task automatic t_table_lru;
        for (int k = 2; k < 8; k++)
            access({28'(k + 1), 4'(k)}, 1'b0, -1, 5, 1, "R3 fill table");
        access(32'h0000_0010, 1'b1, 2, 1, 1, "R10 touch set0");
        access(32'h0000_0098, 1'b0, -1, 5, 1, "R10 ninth set");
        access(32'h0000_0010, 1'b1, 2, 1, 1, "R10 set0 kept");
        access(32'h0000_0021, 1'b1, 3, 4, 1, "R6 R10 set1 evicted, phased hit");
    endtask

    task automatic t_victim;
        for (int t = 1; t <= 5; t++)
            access({28'(t), 4'hA}, 1'b0, -1, -1, -1, "R9 fill set10");
        access(32'h0000_002A, 1'b1, -1, -1, -1, "R9 second tag kept");
        access(32'h0000_001A, 1'b0, -1, -1, -1, "R9 first tag evicted");
    endtask

    task automatic t_addr_split;
        access(32'hFFFF_FFF3, 1'b0, -1, -1, -1, "R1 high tag miss");
        access(32'hFFFF_FFF3, 1'b1, 2, 1, 1, "R1 high tag hit");
        access(32'h0000_0043, 1'b1, 3, 4, 4, "R1 same set other tag");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cold_then_predict();
        t_mispredict();
        t_table_lru();
        t_victim();
        t_addr_split();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule